// File: doc/BRIEF.md
# Lane Packet Framer and Checker

This block is a pair of engines for data packets on one 16-bit lane of a serial link. The lane runs one word per clock, word-aligned, at 125 MHz. The framer takes payload words from a valid/ready stream with an end marker. It wraps them as an opening control word, the payload words, a 16-bit checksum word and a closing control word. Each lane word has a control flag that separates control characters from data. A dedicated virtual channel carries these packets, so the packet type is already known and no type field is sent.

The checker watches the receive lane and hunts for an opening control word. It strips the delimiters and the checksum, forwards the payload words and recomputes the checksum. When the packet ends it gives one verdict: good, or drop with a reason. The checker forwards payload words as soon as it knows they are not the checksum. A consumer must therefore hold a packet's words until the verdict and discard them on drop. Errors are detected and reported only; nothing is retransmitted.

Top module: `pkt_link`

## Requirements
- R1: After a payload word is accepted (`tx_in_valid` and `tx_in_ready` high at a clock edge), it appears on the transmit lane one cycle later as a data word (valid 1, control flag 0). `tx_in_ready` is high only in the payload phase. A packet on the lane is the opening control word, the payload words in order, the checksum as a data word, then the closing control word, and the last two follow each other on consecutive cycles. While the source stalls, the lane shows valid 0.
- R2: The checksum is CRC-16 with polynomial 0x1021, seed 0xFFFF, no bit reflection and no final inversion. It is computed over the payload bytes, the high byte of each 16-bit word first.
- R3: The framer ends a packet after 32 payload words even if the end marker has not come. The words that follow begin a new packet.
- R4: A control word has the control flag set to 1. The opening code is 0xC35A and the closing code is 0xA53C. After the framer sends the opening word, `tx_in_ready` is high in the next cycle.
- R5: The checker forwards each payload word on `rx_out_valid`/`rx_out_word` one cycle after the next data word of the same packet arrives. The delimiters and the checksum word are never forwarded. Data words that arrive outside a packet are ignored.
- R6: A closing word that ends a packet of 4 to 32 payload words with a matching checksum raises `rx_pkt_good` for one cycle, in the cycle after the closing word. `rx_pkt_good` and `rx_pkt_drop` are never high together.
- R7: A packet of legal length with a checksum mismatch raises `rx_pkt_drop` and `rx_crc_err` for one cycle, in the cycle after the closing word.
- R8: A packet ended with fewer than 4 payload words, including none at all, raises `rx_pkt_drop` and `rx_len_err`, with `rx_crc_err` low.
- R9: A 34th data word after an opening word marks the packet over length. In the next cycle `rx_pkt_drop` and `rx_len_err` pulse, only the first 32 words have been forwarded, and the checker goes back to hunting.
- R10: An opening word that arrives while a packet is open raises `rx_pkt_drop` (length and checksum flags low) for the open packet and starts a new one.
- R11: A closing word that arrives while no packet is open raises only `rx_frame_err` for one cycle.
- R12: After reset, all transmit lane outputs, `tx_in_ready` and all checker outputs are low.
- R13: Lane cycles with valid 0 inside a packet neither count as words nor end the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Payload word offered by source |
| tx_in_ready | output | 1 | Framer accepts a payload word |
| tx_in_word | input | 16 | Payload word, high byte sent first |
| tx_in_last | input | 1 | Offered word ends the payload |
| tx_lnk_valid | output | 1 | Transmit lane word present |
| tx_lnk_ctrl | output | 1 | Transmit lane word is a control character |
| tx_lnk_word | output | 16 | Transmit lane word |
| rx_lnk_valid | input | 1 | Receive lane word present |
| rx_lnk_ctrl | input | 1 | Receive lane word is a control character |
| rx_lnk_word | input | 16 | Receive lane word |
| rx_out_valid | output | 1 | Forwarded payload word present |
| rx_out_word | output | 16 | Forwarded payload word |
| rx_pkt_good | output | 1 | Packet verdict: good |
| rx_pkt_drop | output | 1 | Packet verdict: discard its words |
| rx_len_err | output | 1 | Drop reason: payload too short or too long |
| rx_crc_err | output | 1 | Drop reason: checksum mismatch |
| rx_frame_err | output | 1 | Closing word with no open packet |

## Verification
The assertions check the per-cycle rules on every cycle. An accepted word shows up on the lane the next cycle. The opening word is followed by readiness. The closing word follows a data word. Good and drop never coincide, and a length error always comes with a drop. A frame error never comes with forwarded data or a verdict. Forwarded words only follow incoming data words, and the checker's word count stays within 32. Only the bench's scenarios can show that the checksum value is right. They also show the exact verdict for short, long, corrupted and unterminated packets, truncation at 32 words, tolerance of idle gaps, and that randomly sized and stalled packets come back intact through a loopback.

// File: rtl/pkt_link_pkg.sv
package pkt_link_pkg;

    localparam logic [15:0] SOP_CODE  = 16'hC35A;
    localparam logic [15:0] EOP_CODE  = 16'hA53C;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY  = 16'h1021;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_BODY,
        TX_CRC,
        TX_EOP
    } tx_state_e;

    typedef struct packed {
        logic        valid;
        logic        ctrl;
        logic [15:0] word;
    } lane_t;

endpackage

// File: rtl/pkt_crc_step.sv
module pkt_crc_step #(
    parameter int          DW   = 16,
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0]   crc_in,
    input  logic [DW-1:0] data,
    output logic [15:0]   crc_out
);
    // one shift stage per data bit, most significant bit first
    logic [15:0] stage [0:DW];

    assign stage[0] = crc_in;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic fb;
        assign fb = stage[b][15] ^ data[DW-1-b];
        assign stage[b+1] = {stage[b][14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
    end

    assign crc_out = stage[DW];

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
    import pkt_link_pkg::*;
#(
    parameter int MAX_WORDS = 32,
    parameter int CW        = $clog2(MAX_WORDS + 2)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_word,
    input  logic        in_last,
    output logic        lnk_valid,
    output logic        lnk_ctrl,
    output logic [15:0] lnk_word
);
    localparam logic [CW-1:0] LAST_IDX = CW'(MAX_WORDS - 1);

    typedef struct packed {
        tx_state_e   st;
        logic [CW-1:0] cnt;
        logic [15:0] crc;
        lane_t       lane;
    } tx_regs_t;

    tx_regs_t    r_q, r_d;
    logic [15:0] crc_upd;

    pkt_crc_step #(.DW(16), .POLY(CRC_POLY)) i_crc (
        .crc_in (r_q.crc),
        .data   (in_word),
        .crc_out(crc_upd)
    );

    assign in_ready = (r_q.st == TX_BODY);

    always_comb begin
        r_d      = r_q;
        r_d.lane = '0;
        unique case (r_q.st)
            TX_IDLE: begin
                if (in_valid) begin
                    r_d.lane = '{valid: 1'b1, ctrl: 1'b1, word: SOP_CODE};
                    r_d.st   = TX_BODY;
                    r_d.cnt  = '0;
                    r_d.crc  = CRC_SEED;
                end
            end
            TX_BODY: begin
                if (in_valid) begin
                    r_d.lane = '{valid: 1'b1, ctrl: 1'b0, word: in_word};
                    r_d.crc  = crc_upd;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (in_last || r_q.cnt == LAST_IDX) begin
                        r_d.st = TX_CRC;
                    end
                end
            end
            TX_CRC: begin
                r_d.lane = '{valid: 1'b1, ctrl: 1'b0, word: r_q.crc};
                r_d.st   = TX_EOP;
            end
            TX_EOP: begin
                r_d.lane = '{valid: 1'b1, ctrl: 1'b1, word: EOP_CODE};
                r_d.st   = TX_IDLE;
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: TX_IDLE, cnt: '0, crc: CRC_SEED, lane: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign lnk_valid = r_q.lane.valid;
    assign lnk_ctrl  = r_q.lane.ctrl;
    assign lnk_word  = r_q.lane.word;

    // R1
    accept_to_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (lnk_valid && !lnk_ctrl && lnk_word == $past(in_word)));

    // R1
    eop_after_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && lnk_ctrl && lnk_word == EOP_CODE) |-> $past(lnk_valid && !lnk_ctrl));

    // R4
    sop_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && lnk_ctrl && lnk_word == SOP_CODE) |-> in_ready);

endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
    import pkt_link_pkg::*;
#(
    parameter int MIN_WORDS = 4,
    parameter int MAX_WORDS = 32,
    parameter int CW        = $clog2(MAX_WORDS + 2)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lnk_valid,
    input  logic        lnk_ctrl,
    input  logic [15:0] lnk_word,
    output logic        out_valid,
    output logic [15:0] out_word,
    output logic        pkt_good,
    output logic        pkt_drop,
    output logic        len_err,
    output logic        crc_err,
    output logic        frame_err
);
    localparam logic [CW-1:0] MIN_CNT = CW'(MIN_WORDS);
    localparam logic [CW-1:0] MAX_CNT = CW'(MAX_WORDS);

    typedef struct packed {
        logic          open;
        logic          have_pend;
        logic [15:0]   pend;
        logic [15:0]   crc;
        logic [CW-1:0] cnt;
        logic          out_valid;
        logic [15:0]   out_word;
        logic          good;
        logic          drop;
        logic          len_err;
        logic          crc_err;
        logic          frame_err;
    } rx_regs_t;

    rx_regs_t    r_q, r_d;
    logic [15:0] crc_upd;
    logic        is_sop, is_eop, is_dat;
    logic        len_ok, crc_ok;

    pkt_crc_step #(.DW(16), .POLY(CRC_POLY)) i_crc (
        .crc_in (r_q.crc),
        .data   (r_q.pend),
        .crc_out(crc_upd)
    );

    assign is_sop = lnk_valid &&  lnk_ctrl && lnk_word == SOP_CODE;
    assign is_eop = lnk_valid &&  lnk_ctrl && lnk_word == EOP_CODE;
    assign is_dat = lnk_valid && !lnk_ctrl;
    assign len_ok = r_q.have_pend && r_q.cnt >= MIN_CNT;
    assign crc_ok = r_q.have_pend && r_q.pend == r_q.crc;

    always_comb begin
        r_d           = r_q;
        r_d.out_valid = 1'b0;
        r_d.good      = 1'b0;
        r_d.drop      = 1'b0;
        r_d.len_err   = 1'b0;
        r_d.crc_err   = 1'b0;
        r_d.frame_err = 1'b0;
        if (!r_q.open) begin
            if (is_sop) begin
                r_d.open      = 1'b1;
                r_d.have_pend = 1'b0;
                r_d.crc       = CRC_SEED;
                r_d.cnt       = '0;
            end else if (is_eop) begin
                r_d.frame_err = 1'b1;
            end
        end else begin
            if (is_sop) begin
                r_d.drop      = 1'b1;
                r_d.have_pend = 1'b0;
                r_d.crc       = CRC_SEED;
                r_d.cnt       = '0;
            end else if (is_eop) begin
                r_d.open = 1'b0;
                if (len_ok && crc_ok) begin
                    r_d.good = 1'b1;
                end else begin
                    r_d.drop    = 1'b1;
                    r_d.len_err = !len_ok;
                    r_d.crc_err = len_ok && !crc_ok;
                end
            end else if (is_dat) begin
                if (r_q.have_pend && r_q.cnt == MAX_CNT) begin
                    r_d.open    = 1'b0;
                    r_d.drop    = 1'b1;
                    r_d.len_err = 1'b1;
                end else begin
                    if (r_q.have_pend) begin
                        r_d.out_valid = 1'b1;
                        r_d.out_word  = r_q.pend;
                        r_d.crc       = crc_upd;
                        r_d.cnt       = r_q.cnt + 1'b1;
                    end
                    r_d.pend      = lnk_word;
                    r_d.have_pend = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.crc <= CRC_SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.out_valid;
    assign out_word  = r_q.out_word;
    assign pkt_good  = r_q.good;
    assign pkt_drop  = r_q.drop;
    assign len_err   = r_q.len_err;
    assign crc_err   = r_q.crc_err;
    assign frame_err = r_q.frame_err;

    // R6
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_good && pkt_drop));

    // R8
    len_err_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (pkt_drop && !crc_err));

    // R11
    frame_err_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (!out_valid && !pkt_good && !pkt_drop));

    // R5
    fwd_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(lnk_valid && !lnk_ctrl));

    // R9
    fwd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= MAX_CNT);

endmodule

// File: rtl/pkt_link.sv
module pkt_link
    import pkt_link_pkg::*;
#(
    parameter int MIN_WORDS = 4,
    parameter int MAX_WORDS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_in_valid,
    output logic        tx_in_ready,
    input  logic [15:0] tx_in_word,
    input  logic        tx_in_last,
    output logic        tx_lnk_valid,
    output logic        tx_lnk_ctrl,
    output logic [15:0] tx_lnk_word,
    input  logic        rx_lnk_valid,
    input  logic        rx_lnk_ctrl,
    input  logic [15:0] rx_lnk_word,
    output logic        rx_out_valid,
    output logic [15:0] rx_out_word,
    output logic        rx_pkt_good,
    output logic        rx_pkt_drop,
    output logic        rx_len_err,
    output logic        rx_crc_err,
    output logic        rx_frame_err
);
    localparam int CW = $clog2(MAX_WORDS + 2);

    pkt_framer #(.MAX_WORDS(MAX_WORDS), .CW(CW)) i_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_in_valid),
        .in_ready (tx_in_ready),
        .in_word  (tx_in_word),
        .in_last  (tx_in_last),
        .lnk_valid(tx_lnk_valid),
        .lnk_ctrl (tx_lnk_ctrl),
        .lnk_word (tx_lnk_word)
    );

    pkt_deframer #(.MIN_WORDS(MIN_WORDS), .MAX_WORDS(MAX_WORDS), .CW(CW)) i_deframer (
        .clk      (clk),
        .rst_n    (rst_n),
        .lnk_valid(rx_lnk_valid),
        .lnk_ctrl (rx_lnk_ctrl),
        .lnk_word (rx_lnk_word),
        .out_valid(rx_out_valid),
        .out_word (rx_out_word),
        .pkt_good (rx_pkt_good),
        .pkt_drop (rx_pkt_drop),
        .len_err  (rx_len_err),
        .crc_err  (rx_crc_err),
        .frame_err(rx_frame_err)
    );

endmodule

// File: tb/test_pkt_link.sv
module test_pkt_link;

    localparam logic [15:0] SOPW = 16'hC35A;
    localparam logic [15:0] EOPW = 16'hA53C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_in_valid = 1'b0;
    logic        tx_in_ready;
    logic [15:0] tx_in_word = '0;
    logic        tx_in_last = 1'b0;
    logic        tx_lnk_valid, tx_lnk_ctrl;
    logic [15:0] tx_lnk_word;
    logic        rx_lnk_valid, rx_lnk_ctrl;
    logic [15:0] rx_lnk_word;
    logic        rx_out_valid;
    logic [15:0] rx_out_word;
    logic        rx_pkt_good, rx_pkt_drop, rx_len_err, rx_crc_err, rx_frame_err;

    logic        loop = 1'b0;
    logic        inj_v = 1'b0, inj_c = 1'b0;
    logic [15:0] inj_w = '0;

    assign rx_lnk_valid = loop ? tx_lnk_valid : inj_v;
    assign rx_lnk_ctrl  = loop ? tx_lnk_ctrl  : inj_c;
    assign rx_lnk_word  = loop ? tx_lnk_word  : inj_w;

    always #4 clk = ~clk;

    pkt_link i_pkt_link (
        .clk(clk), .rst_n(rst_n),
        .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
        .tx_in_word(tx_in_word), .tx_in_last(tx_in_last),
        .tx_lnk_valid(tx_lnk_valid), .tx_lnk_ctrl(tx_lnk_ctrl), .tx_lnk_word(tx_lnk_word),
        .rx_lnk_valid(rx_lnk_valid), .rx_lnk_ctrl(rx_lnk_ctrl), .rx_lnk_word(rx_lnk_word),
        .rx_out_valid(rx_out_valid), .rx_out_word(rx_out_word),
        .rx_pkt_good(rx_pkt_good), .rx_pkt_drop(rx_pkt_drop),
        .rx_len_err(rx_len_err), .rx_crc_err(rx_crc_err), .rx_frame_err(rx_frame_err)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // monitor
    int          tx_n = 0, out_n = 0;
    int          n_good = 0, n_drop = 0, n_len = 0, n_crc = 0, n_frame = 0;
    logic [16:0] tx_cap [0:2047];
    logic [15:0] out_cap [0:2047];

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_lnk_valid) begin
                tx_cap[tx_n % 2048] = {tx_lnk_ctrl, tx_lnk_word};
                tx_n = tx_n + 1;
            end
            if (rx_out_valid) begin
                out_cap[out_n % 2048] = rx_out_word;
                out_n = out_n + 1;
            end
            n_good  = n_good  + int'(rx_pkt_good);
            n_drop  = n_drop  + int'(rx_pkt_drop);
            n_len   = n_len   + int'(rx_len_err);
            n_crc   = n_crc   + int'(rx_crc_err);
            n_frame = n_frame + int'(rx_frame_err);
        end
    end

    int b_tx, b_out, b_good, b_drop, b_len, b_crc, b_frame;

    task automatic snap();
        b_tx = tx_n; b_out = out_n; b_good = n_good; b_drop = n_drop;
        b_len = n_len; b_crc = n_crc; b_frame = n_frame;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_verdict(input string tag, input int g, input int d, input int l,
                               input int c, input int f);
        chk({tag, " good"},  n_good  - b_good,  g);
        chk({tag, " drop"},  n_drop  - b_drop,  d);
        chk({tag, " len"},   n_len   - b_len,   l);
        chk({tag, " crc"},   n_crc   - b_crc,   c);
        chk({tag, " frame"}, n_frame - b_frame, f);
    endtask

    // reference checksum, byte at a time
    function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] x;
        x = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) begin
            if (x[15]) x = (x << 1) ^ 16'h1021;
            else       x = x << 1;
        end
        return x;
    endfunction

    logic [15:0] pay [0:63];

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = ref_byte(c, pay[i][15:8]);
            c = ref_byte(c, pay[i][7:0]);
        end
        return c;
    endfunction

    // source side: offer n words, random stalls
    task automatic tx_send(input int n, input int stall_pct);
        int i;
        i = 0;
        while (i < n) begin
            @(negedge clk);
            if (int'($urandom % 100) < stall_pct) begin
                tx_in_valid = 1'b0;
            end else begin
                tx_in_valid = 1'b1;
                tx_in_word  = pay[i];
                tx_in_last  = (i == n - 1);
                if (tx_in_ready) i++;
            end
        end
        @(negedge clk);
        tx_in_valid = 1'b0;
        tx_in_last  = 1'b0;
    endtask

    task automatic inj(input logic c, input logic [15:0] w);
        @(negedge clk);
        inj_v = 1'b1; inj_c = c; inj_w = w;
    endtask

    task automatic inj_idle(input int k);
        repeat (k) begin
            @(negedge clk);
            inj_v = 1'b0; inj_c = 1'b0; inj_w = '0;
        end
    endtask

    // injected packet: n payload words, optional corrupt checksum, optional gaps
    task automatic inj_pkt(input int n, input bit bad, input bit gaps);
        logic [15:0] c;
        c = ref_crc(n) ^ (bad ? 16'h0001 : 16'h0000);
        inj(1'b1, SOPW);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 2 == 1)) inj_idle(2);
            inj(1'b0, pay[i]);
        end
        inj(1'b0, c);
        inj(1'b1, EOPW);
        inj_idle(4);
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) pay[i] = 16'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 tx lane", {tx_lnk_valid, tx_lnk_ctrl, tx_lnk_word}, 0);
        chk("R12 ready", tx_in_ready, 0);
        chk("R12 rx outs", {rx_out_valid, rx_pkt_good, rx_pkt_drop, rx_len_err,
                            rx_crc_err, rx_frame_err}, 0);

        // R11 closing word with no packet, R5 stray data ignored
        snap();
        inj(1'b0, 16'h1234);
        inj(1'b1, EOPW);
        inj_idle(3);
        chk("R5 stray data not forwarded", out_n - b_out, 0);
        chk_verdict("R11 stray close", 0, 0, 0, 0, 1);

        // R6 R13 good packet with idle gaps
        fill(6); snap();
        inj_pkt(6, 1'b0, 1'b1);
        chk_verdict("R13 gapped good", 1, 0, 0, 0, 0);
        chk("R5 fwd count", out_n - b_out, 6);
        for (int i = 0; i < 6; i++) chk("R5 fwd word", out_cap[(b_out + i) % 2048], pay[i]);

        // R7 checksum mismatch
        fill(8); snap();
        inj_pkt(8, 1'b1, 1'b0);
        chk_verdict("R7 bad crc", 0, 1, 0, 1, 0);

        // R8 short: 3 words, none, one word only
        fill(3); snap();
        inj_pkt(3, 1'b0, 1'b0);
        chk_verdict("R8 three words", 0, 1, 1, 0, 0);
        snap();
        inj(1'b1, SOPW); inj(1'b1, EOPW); inj_idle(3);
        chk_verdict("R8 empty", 0, 1, 1, 0, 0);
        snap();
        inj(1'b1, SOPW); inj(1'b0, 16'hBEEF); inj(1'b1, EOPW); inj_idle(3);
        chk_verdict("R8 lone word", 0, 1, 1, 0, 0);
        chk("R8 lone word not forwarded", out_n - b_out, 0);

        // R6 boundaries: 4 and 32 words
        fill(4); snap();
        inj_pkt(4, 1'b0, 1'b0);
        chk_verdict("R6 min len", 1, 0, 0, 0, 0);
        fill(32); snap();
        inj_pkt(32, 1'b0, 1'b0);
        chk_verdict("R6 max len", 1, 0, 0, 0, 0);
        chk("R6 max fwd", out_n - b_out, 32);

        // R9 over length: 34 data words
        fill(34); snap();
        inj(1'b1, SOPW);
        for (int i = 0; i < 34; i++) inj(1'b0, pay[i]);
        inj_idle(2);
        chk_verdict("R9 overlong", 0, 1, 1, 0, 0);
        chk("R9 fwd count", out_n - b_out, 32);
        snap();
        inj(1'b1, EOPW); inj_idle(3);
        chk_verdict("R9 trailing close", 0, 0, 0, 0, 1);

        // R10 missing close then good packet
        fill(5); snap();
        inj(1'b1, SOPW);
        for (int i = 0; i < 5; i++) inj(1'b0, pay[i]);
        inj_idle(1);
        fill(4);
        inj_pkt(4, 1'b0, 1'b0);
        chk_verdict("R10 reopen", 1, 1, 0, 0, 0);
        chk("R10 fwd count", out_n - b_out, 8);

        // loopback: random lengths and stalls
        loop = 1'b1;
        inj_idle(1);
        for (int p = 0; p < 40; p++) begin
            int n;
            n = 4 + int'($urandom % 29);
            if (p == 0) n = 4;
            if (p == 1) n = 32;
            fill(n); snap();
            tx_send(n, (p % 3) * 20);
            repeat (6) @(negedge clk);
            chk("R1 lane count", tx_n - b_tx, n + 3);
            chk("R4 open word", tx_cap[b_tx % 2048], {1'b1, SOPW});
            for (int i = 0; i < n; i++)
                chk("R1 lane payload", tx_cap[(b_tx + 1 + i) % 2048], {1'b0, pay[i]});
            chk("R2 checksum", tx_cap[(b_tx + 1 + n) % 2048], {1'b0, ref_crc(n)});
            chk("R4 close word", tx_cap[(b_tx + 2 + n) % 2048], {1'b1, EOPW});
            chk_verdict("R6 loopback", 1, 0, 0, 0, 0);
            chk("R5 loopback fwd", out_n - b_out, n);
            for (int i = 0; i < n; i++)
                chk("R5 loopback word", out_cap[(b_out + i) % 2048], pay[i]);
        end

        // R3 truncation: 35 words offered with one end marker
        fill(35); snap();
        tx_send(35, 0);
        repeat (8) @(negedge clk);
        chk("R3 lane count", tx_n - b_tx, 35 + 6);
        chk("R3 first crc", tx_cap[(b_tx + 33) % 2048], {1'b0, ref_crc(32)});
        chk("R3 first close", tx_cap[(b_tx + 34) % 2048], {1'b1, EOPW});
        chk("R3 second open", tx_cap[(b_tx + 35) % 2048], {1'b1, SOPW});
        chk("R3 second word", tx_cap[(b_tx + 36) % 2048], {1'b0, pay[32]});
        chk_verdict("R3 verdicts", 1, 1, 1, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule